// File: doc/BRIEF.md
# Four-Channel Power Switch Fault Sequencer

This block is the digital control core for four independent power-switch channels. Each channel receives a digitized power-good level, an over-current level and an under-current level from external analog sensing. In return it drives one gate-on output per channel. For every channel the block steps through turn-on, power-good qualification, an open-circuit check delay and current-limit supervision. It keeps latched fault bits and pulls an active-low fault line whenever any fault bit is set, so a host does not have to poll.

The host reaches the block through a small parallel register port. A write to the control register enables or disables channels and clears every latched fault. A setup register selects the open-circuit check delay and the retry spacing after a current-limit trip. Two read-only registers report which switches are on and which faults were recorded.

Register addresses (2-bit `reg_addr`): 0 is control, 1 is setup, 2 is power status and 3 is fault status. Reads are combinational. Writes take effect at the clock edge where `reg_wr` is high.

Top module: `pwr_fault_seq`

## Requirements
- R1: After reset every gate output is 0 and `fault_n_o` is 1. The power status register reads 0x10 and the fault status register reads 0x00.
- R2: The setup register holds the open-circuit delay select in bits 7:6 and the retry spacing bit in bit 5. It reads back those bits and 0 elsewhere. Power status reads bit 4 as 1, bits 7:5 as 0 and bits 3:0 as the per-channel switch-on flags. Fault status holds the current-limit faults in bits 3:0 and the open-circuit faults in bits 7:4.
- R3: Setting control bit i turns gate i on two cycles after the write cycle. Once power-good i is high with the gate on, switch-on flag i is set at the next clock edge.
- R4: The open-circuit check delay starts when the switch-on flag is set. For delay select values 0, 1, 2 and 3 it expires 256, 512, 1024 and 2048 clock edges later. An open-circuit fault bit is set at that expiry edge only if under-current is high there. The gate stays on after an open-circuit fault.
- R5: Over-current high for 16 consecutive clock edges on an active channel turns its gate off, clears its switch-on flag and sets its current-limit fault bit, all at the 16th edge. A shorter burst has no effect.
- R6: `fault_n_o` is low while any fault bit is set. A control register write clears all fault bits at its edge. A fault event at that same edge still sets its bit.
- R7: After a current-limit trip the gate stays off until the fault bit is cleared and 128 cycles have passed (retry bit 0) or 256 cycles have passed (retry bit 1), counted from the trip edge. The channel then turns its gate on again if it is still enabled.
- R8: A disabled channel turns its gate off and clears its switch-on flag. A disabled or latched-off channel ignores its over-current and under-current inputs.
- R9: If power-good falls while the switch-on flag is set, the flag clears at the next edge and the gate stays on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| pgood_i | input | 4 | Per-channel power-good level |
| ovc_i | input | 4 | Per-channel over-current level |
| unc_i | input | 4 | Per-channel under-current level |
| gate_o | output | 4 | Per-channel gate-on |
| fault_n_o | output | 1 | Active-low fault interrupt |

## Verification
Every result has a fixed due cycle, counted from the edge that captures the stimulus. A switch-on flag, fault bit or fault line moves one edge after its cause. A gate moves two edges after a control write. A current-limit trip lands 16 edges after over-current first goes high, an open-circuit fault lands 256 to 2048 edges after power-good, and a retry lands 128 or 256 edges after the trip. The driver computes each due cycle from these rules and queues the expected value. The monitor checks the outputs at the falling edge of that cycle, and for timers it also checks the cycle before, so a one-edge slip is caught.

// File: rtl/pwr_fault_seq_pkg.sv
package pwr_fault_seq_pkg;

  typedef enum logic [1:0] {
    CH_OFF   = 2'd0,
    CH_RAMP  = 2'd1,
    CH_ON    = 2'd2,
    CH_LATCH = 2'd3
  } ch_state_e;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_SETUP  = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;
  localparam logic [1:0] ADDR_FAULT  = 2'd3;

  // open-circuit check delay: base unit doubled per select step
  function automatic int unsigned oc_delay_ticks(input int unsigned unit,
                                                 input logic [1:0] sel);
    return unit << sel;
  endfunction

  // off time after a current-limit trip: 8x or 16x the limit window
  function automatic int unsigned retry_ticks(input int unsigned cl_ticks,
                                              input logic slow);
    return cl_ticks << (slow ? 4 : 3);
  endfunction

endpackage

// File: rtl/pwr_fault_seq_regs.sv
module pwr_fault_seq_regs
  import pwr_fault_seq_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [1:0]     reg_addr,
  input  logic [7:0]     reg_wdata,
  output logic [7:0]     reg_rdata,
  input  logic [NCH-1:0] pwr_ok,
  input  logic [NCH-1:0] cl_flt,
  input  logic [NCH-1:0] oc_flt,
  output logic [NCH-1:0] ch_en,
  output logic [1:0]     dly_sel,
  output logic           retry_slow,
  output logic           flt_clr
);

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;

  assign flt_clr = reg_wr && (reg_addr == ADDR_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch_en      <= '0;
      dly_sel    <= 2'd0;
      retry_slow <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr == ADDR_CTRL)  ch_en <= reg_wdata[NCH-1:0];
      if (reg_addr == ADDR_SETUP) begin
        dly_sel    <= reg_wdata[7:6];
        retry_slow <= reg_wdata[5];
      end
    end
  end

  always_comb begin
    unique case (reg_addr)
      ADDR_CTRL:   reg_rdata = 8'(ch_en);
      ADDR_SETUP:  reg_rdata = {dly_sel, retry_slow, 5'b00000};
      ADDR_STATUS: reg_rdata = 8'h10 | 8'(pwr_ok);
      default:     reg_rdata = (8'(oc_flt) << 4) | 8'(cl_flt);
    endcase
  end

endmodule

// File: rtl/pwr_fault_seq_chan.sv
module pwr_fault_seq_chan
  import pwr_fault_seq_pkg::*;
#(
  parameter int CL_TICKS = 16,
  parameter int OC_UNIT  = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] dly_sel,
  input  logic       retry_slow,
  input  logic       flt_clr,
  input  logic       pgood,
  input  logic       ovc,
  input  logic       unc,
  output logic       gate,
  output logic       pwr_ok,
  output logic       cl_flt,
  output logic       oc_flt,
  output logic       trip,
  output logic       oc_evt
);

  localparam int CLW = $clog2(CL_TICKS + 1);
  localparam int OCW = $clog2(OC_UNIT * 8);
  localparam int RTW = $clog2(CL_TICKS * 16);
  localparam logic [CLW-1:0] CL_LAST = CLW'(CL_TICKS - 1);

  ch_state_e      state;
  logic [CLW-1:0] cl_cnt;
  logic [OCW-1:0] oc_cnt;
  logic [RTW-1:0] rt_cnt;
  logic           oc_run;
  logic           active;
  logic           oc_expire;
  logic [OCW-1:0] oc_last;
  logic [RTW-1:0] rt_load;

  assign oc_last = OCW'(oc_delay_ticks(OC_UNIT, dly_sel) - 1);
  assign rt_load = RTW'(retry_ticks(CL_TICKS, retry_slow) - 1);

  assign active    = en && (state == CH_RAMP || state == CH_ON);
  assign trip      = active && ovc && (cl_cnt == CL_LAST);
  assign oc_expire = en && (state == CH_ON) && pgood && !trip && oc_run && (oc_cnt == oc_last);
  assign oc_evt    = oc_expire && unc;

  assign gate   = (state == CH_RAMP) || (state == CH_ON);
  assign pwr_ok = (state == CH_ON);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= CH_OFF;
      cl_cnt <= '0;
      oc_cnt <= '0;
      rt_cnt <= '0;
      oc_run <= 1'b0;
      cl_flt <= 1'b0;
      oc_flt <= 1'b0;
    end else begin
      cl_cnt <= (active && ovc && !trip) ? cl_cnt + 1'b1 : '0;

      unique case (state)
        CH_OFF: if (en) state <= CH_RAMP;
        CH_RAMP: begin
          if (!en) state <= CH_OFF;
          else if (trip) begin
            state  <= CH_LATCH;
            rt_cnt <= rt_load;
          end else if (pgood) begin
            state  <= CH_ON;
            oc_cnt <= '0;
            oc_run <= 1'b1;
          end
        end
        CH_ON: begin
          if (!en) state <= CH_OFF;
          else if (trip) begin
            state  <= CH_LATCH;
            rt_cnt <= rt_load;
          end else if (!pgood) state <= CH_RAMP;
          else if (oc_run) begin
            if (oc_cnt == oc_last) oc_run <= 1'b0;
            else oc_cnt <= oc_cnt + 1'b1;
          end
        end
        default: begin
          if (rt_cnt != '0) rt_cnt <= rt_cnt - 1'b1;
          else if (!cl_flt) state <= en ? CH_RAMP : CH_OFF;
        end
      endcase

      if (trip) cl_flt <= 1'b1;
      else if (flt_clr) cl_flt <= 1'b0;

      if (oc_evt) oc_flt <= 1'b1;
      else if (flt_clr) oc_flt <= 1'b0;
    end
  end

endmodule

// File: rtl/pwr_fault_seq.sv
module pwr_fault_seq
  import pwr_fault_seq_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int CL_TICKS = 16,
  parameter int OC_UNIT  = 256
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [1:0]     reg_addr,
  input  logic [7:0]     reg_wdata,
  output logic [7:0]     reg_rdata,
  input  logic [NCH-1:0] pgood_i,
  input  logic [NCH-1:0] ovc_i,
  input  logic [NCH-1:0] unc_i,
  output logic [NCH-1:0] gate_o,
  output logic           fault_n_o
);

  logic [NCH-1:0] en_w;
  logic [NCH-1:0] pwr_ok_w;
  logic [NCH-1:0] cl_flt_w;
  logic [NCH-1:0] oc_flt_w;
  logic [NCH-1:0] trip_w;
  logic [NCH-1:0] ocevt_w;
  logic [1:0]     dly_sel_w;
  logic           retry_slow_w;
  logic           clr_w;

  pwr_fault_seq_regs #(.NCH(NCH)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .pwr_ok     (pwr_ok_w),
    .cl_flt     (cl_flt_w),
    .oc_flt     (oc_flt_w),
    .ch_en      (en_w),
    .dly_sel    (dly_sel_w),
    .retry_slow (retry_slow_w),
    .flt_clr    (clr_w)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwr_fault_seq_chan #(.CL_TICKS(CL_TICKS), .OC_UNIT(OC_UNIT)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en_w[g]),
      .dly_sel    (dly_sel_w),
      .retry_slow (retry_slow_w),
      .flt_clr    (clr_w),
      .pgood      (pgood_i[g]),
      .ovc        (ovc_i[g]),
      .unc        (unc_i[g]),
      .gate       (gate_o[g]),
      .pwr_ok     (pwr_ok_w[g]),
      .cl_flt     (cl_flt_w[g]),
      .oc_flt     (oc_flt_w[g]),
      .trip       (trip_w[g]),
      .oc_evt     (ocevt_w[g])
    );
  end

  assign fault_n_o = !((|cl_flt_w) || (|oc_flt_w));

endmodule

// File: rtl/pwr_fault_seq_chk.sv
module pwr_fault_seq_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_wr,
  input logic [1:0]     reg_addr,
  input logic [7:0]     reg_rdata,
  input logic [NCH-1:0] ovc_i,
  input logic [NCH-1:0] gate_o,
  input logic           fault_n_o,
  input logic [NCH-1:0] en_w,
  input logic [NCH-1:0] pwr_ok_w,
  input logic [NCH-1:0] trip_w,
  input logic [NCH-1:0] ocevt_w
);

  assert_trip_gate_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|trip_w) |=> ((gate_o & $past(trip_w)) == '0));

  assert_trip_needs_ovc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|trip_w) |-> ((trip_w & ~ovc_i) == '0));

  assert_fault_line_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|trip_w) || (|ocevt_w)) |=> !fault_n_o);

  assert_clear_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && !(|trip_w) && !(|ocevt_w)) |=> fault_n_o);

  assert_on_flag_needs_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwr_ok_w & ~gate_o) == '0));

  assert_disabled_gate_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((gate_o & ~$past(en_w)) == '0));

  assert_status_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd2) |-> (reg_rdata[7:4] == 4'b0001));

endmodule

bind pwr_fault_seq pwr_fault_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .ovc_i     (ovc_i),
  .gate_o    (gate_o),
  .fault_n_o (fault_n_o),
  .en_w      (en_w),
  .pwr_ok_w  (pwr_ok_w),
  .trip_w    (trip_w),
  .ocevt_w   (ocevt_w)
);

// File: tb/pwr_fault_seq_tb_top.sv
module pwr_fault_seq_tb_top;

  localparam int K_GATE = 0;
  localparam int K_FLTN = 1;
  localparam int K_REG  = 2;

  typedef struct {
    int         due;
    int         kind;
    logic [7:0] val;
    string      req;
  } sb_item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [3:0] pgood_i = 4'd0;
  logic [3:0] ovc_i = 4'd0;
  logic [3:0] unc_i = 4'd0;
  logic [3:0] gate_o;
  logic       fault_n_o;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  sb_item_t sb[$];

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  pwr_fault_seq dut_i (
    .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .pgood_i (pgood_i),
    .ovc_i (ovc_i), .unc_i (unc_i), .gate_o (gate_o), .fault_n_o (fault_n_o)
  );

  // expected timing rules restated independently
  function automatic int exp_oc_delay(input int sel);
    case (sel)
      0: return 256;
      1: return 512;
      2: return 1024;
      default: return 2048;
    endcase
  endfunction

  function automatic int exp_retry(input bit slow);
    return slow ? 16 * 16 : 8 * 16;
  endfunction

  task automatic push_at(input int due, input int kind, input logic [7:0] val, input string req);
    sb_item_t it;
    int pos;
    it.due = due; it.kind = kind; it.val = val; it.req = req;
    pos = sb.size();
    for (int i = 0; i < sb.size(); i++) begin
      if (sb[i].due > due) begin
        pos = i;
        break;
      end
    end
    sb.insert(pos, it);
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_wr = 1'b0;
  endtask

  task automatic chk_reg(input logic [1:0] a, input logic [7:0] v, input string req);
    reg_addr = a;
    push_at(cyc, K_REG, v, req);
    tick(1);
  endtask

  // monitor: pops due items and compares at the falling edge
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      sb_item_t it;
      logic [7:0] got;
      it = sb.pop_front();
      case (it.kind)
        K_GATE:  got = {4'b0000, gate_o};
        K_FLTN:  got = {7'b0, fault_n_o};
        default: got = reg_rdata;
      endcase
      checks++;
      if (it.due != cyc) begin
        errors++;
        $display("FAIL %s: item due at cycle %0d missed (now %0d), expected %02h", it.req, it.due, cyc, it.val);
      end else if (got !== it.val) begin
        errors++;
        $display("FAIL %s: cycle %0d kind %0d actual %02h expected %02h", it.req, cyc, it.kind, got, it.val);
      end
    end
  end

  initial begin
    int t;
    int trip_cyc;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    push_at(cyc, K_GATE, 8'h00, "R1");
    push_at(cyc, K_FLTN, 8'h01, "R1");
    chk_reg(2'd2, 8'h10, "R1");
    chk_reg(2'd3, 8'h00, "R1");

    // R2 setup field read-back
    reg_write(2'd1, 8'hFF);
    chk_reg(2'd1, 8'hE0, "R2");
    reg_write(2'd1, 8'h00);
    chk_reg(2'd1, 8'h00, "R2");

    // R3 enable channel 0
    reg_write(2'd0, 8'h01);
    push_at(cyc, K_GATE, 8'h00, "R3");
    push_at(cyc + 1, K_GATE, 8'h01, "R3");
    tick(2);

    // R3/R4 power-good, open-circuit with under-current held (delay select 0)
    pgood_i[0] = 1'b1; unc_i[0] = 1'b1;
    t = cyc;
    tick(1);
    chk_reg(2'd2, 8'h11, "R3");
    push_at(t + exp_oc_delay(0), K_FLTN, 8'h01, "R4");
    push_at(t + 1 + exp_oc_delay(0), K_FLTN, 8'h00, "R4");
    push_at(t + 1 + exp_oc_delay(0), K_GATE, 8'h01, "R4");
    tick(t + exp_oc_delay(0) + 4 - cyc);
    chk_reg(2'd3, 8'h10, "R4");
    unc_i[0] = 1'b0;

    // R6 control write clears
    reg_write(2'd0, 8'h01);
    push_at(cyc, K_FLTN, 8'h01, "R6");
    chk_reg(2'd3, 8'h00, "R6");

    // R9 power-good lost
    pgood_i[0] = 1'b0;
    tick(1);
    push_at(cyc, K_GATE, 8'h01, "R9");
    chk_reg(2'd2, 8'h10, "R9");
    pgood_i[0] = 1'b1;
    tick(3);

    // R5 short burst of 15 cycles
    ovc_i[0] = 1'b1;
    tick(15);
    ovc_i[0] = 1'b0;
    push_at(cyc + 1, K_GATE, 8'h01, "R5");
    push_at(cyc + 3, K_FLTN, 8'h01, "R5");
    tick(5);

    // R5 trip, R7 no retry without clear (retry bit 0)
    ovc_i[0] = 1'b1;
    t = cyc;
    trip_cyc = t + 16;
    push_at(t + 15, K_GATE, 8'h01, "R5");
    push_at(trip_cyc, K_GATE, 8'h00, "R5");
    push_at(trip_cyc, K_FLTN, 8'h00, "R5");
    tick(17);
    chk_reg(2'd2, 8'h10, "R5");
    chk_reg(2'd3, 8'h01, "R5");
    push_at(trip_cyc + 40, K_FLTN, 8'h00, "R8");  // over-current still high while latched
    tick(trip_cyc + 50 - cyc);
    ovc_i[0] = 1'b0;
    push_at(trip_cyc + exp_retry(1'b0) + 60, K_GATE, 8'h00, "R7");
    tick(trip_cyc + exp_retry(1'b0) + 62 - cyc);
    reg_write(2'd0, 8'h01);
    push_at(cyc, K_GATE, 8'h00, "R7");
    push_at(cyc + 1, K_GATE, 8'h01, "R7");
    tick(4);

    // R7 retry bit 1 with early clear
    reg_write(2'd1, 8'h20);
    ovc_i[0] = 1'b1;
    t = cyc;
    trip_cyc = t + 16;
    tick(20);
    ovc_i[0] = 1'b0;
    reg_write(2'd0, 8'h01);
    push_at(cyc, K_FLTN, 8'h01, "R6");
    push_at(trip_cyc + exp_retry(1'b1) - 1, K_GATE, 8'h00, "R7");
    push_at(trip_cyc + exp_retry(1'b1), K_GATE, 8'h01, "R7");
    tick(trip_cyc + exp_retry(1'b1) + 3 - cyc);

    // R4 delay select 1, under-current drops before expiry
    reg_write(2'd1, 8'h40);
    reg_write(2'd0, 8'h03);
    tick(3);
    pgood_i[1] = 1'b1; unc_i[1] = 1'b1;
    t = cyc;
    tick(400);
    unc_i[1] = 1'b0;
    push_at(t + 1 + exp_oc_delay(1), K_FLTN, 8'h01, "R4");
    tick(t + exp_oc_delay(1) + 5 - cyc);
    chk_reg(2'd3, 8'h00, "R4");

    // R4 delay select 3 on channel 2
    reg_write(2'd1, 8'hC0);
    reg_write(2'd0, 8'h07);
    tick(3);
    pgood_i[2] = 1'b1; unc_i[2] = 1'b1;
    t = cyc;
    push_at(t + exp_oc_delay(3), K_FLTN, 8'h01, "R4");
    push_at(t + 1 + exp_oc_delay(3), K_FLTN, 8'h00, "R4");
    tick(t + exp_oc_delay(3) + 4 - cyc);
    chk_reg(2'd3, 8'h40, "R4");
    unc_i[2] = 1'b0;

    // R8 disable channel 0 (write also clears faults)
    reg_write(2'd0, 8'h06);
    push_at(cyc, K_GATE, 8'h07, "R8");
    push_at(cyc + 1, K_GATE, 8'h06, "R8");
    tick(2);
    ovc_i[0] = 1'b1; unc_i[0] = 1'b1;
    tick(40);
    push_at(cyc, K_FLTN, 8'h01, "R8");
    chk_reg(2'd3, 8'h00, "R8");
    chk_reg(2'd2, 8'h16, "R8");
    ovc_i[0] = 1'b0; unc_i[0] = 1'b0;
    tick(3);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done && sb.size() == 0);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
      end
    join_any
    #1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule